// File: doc/BRIEF.md
# Memory Self-Test Engine

This controller exercises a synchronous memory of 32-bit words through a simple request port and reports whether the memory returned exactly what was stored. Software or a boot sequencer pulses `start_i` with a mode, a word-aligned base byte address and a byte length. The engine then runs three passes over the chosen range without any further help. Pass one writes a known sequence. Pass two reads each word back, compares it and overwrites it with its complement. Pass three reads the complements back and compares them.

Two sequences are available. The integrity sequence covers the whole requested range with an incrementing count that starts at 1. The bus sequence always covers exactly as many words as the data bus has bits, and places a single set bit at position i in word i. After pass two that word holds a single cleared bit. The expected value is produced again by a small generator that restarts at the head of every pass, so nothing is stored. The engine stops at the first wrong word. It keeps the failing address together with the expected and received data, and raises `done_o`, plus `fail_o` when a word was wrong. These results stay unchanged until the next accepted start.

States: `ST_IDLE` (after reset) and `ST_DONE` (result held) both accept a start. A start goes to `ST_FILL`, or straight to `ST_DONE` when the word count is zero. `ST_FILL` writes one word per cycle and moves to `ST_RD_REQ` after its last word. `ST_RD_REQ` issues a one-cycle read and moves to `ST_RD_WAIT`. `ST_RD_WAIT` waits for read-valid. A mismatch sends it to `ST_DONE`. A match in the check pass sends it to `ST_INV_WR`. A match in the verify pass sends it back to `ST_RD_REQ`, or to `ST_DONE` after the last word. `ST_INV_WR` writes the complement and returns to `ST_RD_REQ`; after the last word it also switches to the verify pass.

Top module: `mst_engine`

## Requirements
- R1: After reset `done_o`, `fail_o`, `busy_o` and `mem_req_o` are all low.
- R2: A start is taken only in idle or done. It samples `mode_i`, `base_i` and `size_i`, and `busy_o` then stays high until `done_o`. A start pulse while busy changes nothing: the run in progress goes on with its original settings.
- R3: Word i of a run is at byte address `base_i + 4*i`. `mode_i` = 0 selects the integrity sequence, which covers ceil(`size_i`/4) words. `mode_i` = 1 selects the bus sequence, which covers 32 words and ignores `size_i`. No address outside the range is touched.
- R4: In integrity mode the first pass writes the value i+1 to word i.
- R5: The second pass reads each word, compares it with the first-pass value and on a match writes its bitwise complement to the same address.
- R6: The third pass reads each word and compares it with the complement, issuing no writes.
- R7: In bus mode the first pass writes a word with only bit i set to word i. The second pass checks it and writes its complement, and the third pass checks the complement.
- R8: A read is a request with `mem_we_o` low lasting one cycle. No new request follows until `mem_rvalid_i` arrives, and read-valid is ignored while no read is outstanding.
- R9: On the first mismatch the engine issues no more requests and raises `done_o` and `fail_o`. It presents the failing word address on `fail_addr_o`, the expected value on `exp_o` and the received value on `act_o`.
- R10: `done_o`, `fail_o`, `fail_addr_o`, `exp_o` and `act_o` hold until the next accepted start, which clears the failure outputs.
- R11: `done_o` with `fail_o` low is reported only after all three passes have completed over the full range.
- R12: An integrity run with `size_i` = 0 reaches done with a pass on the clock edge after the start and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| mode_i | input | 1 | 0 integrity, 1 bus sequence |
| base_i | input | AW | Word-aligned base byte address |
| size_i | input | AW | Range length in bytes (integrity mode) |
| mem_req_o | output | 1 | Memory request, one cycle per access |
| mem_we_o | output | 1 | High for a write request |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with read-valid |
| mem_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, result held |
| fail_o | output | 1 | A mismatch was found |
| fail_addr_o | output | AW | Address of the failing word |
| exp_o | output | DW | Value the failing word should have held |
| act_o | output | DW | Value the failing word returned |

## Verification
The assertions check on every cycle the following properties:
- reads stay single-cycle and do not overlap;
- the verify pass never writes;
- bus-mode writes carry a single set or a single cleared bit;
- consecutive words step by four bytes;
- fail never appears without done;
- the held results stay stable;
- a finished engine stays silent on the memory port.

Only the bench scenarios can show the rest: the memory contents the passes leave behind, the exact word counts, that a fault is caught in the right pass with the right expected and actual values, that a start during a run is ignored, and that a zero size finishes at once.

// File: rtl/mst_pkg.sv
package mst_pkg;

    typedef enum logic {
        MODE_INTEG = 1'b0,
        MODE_BUS   = 1'b1
    } mst_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_INV_WR,
        ST_DONE
    } mst_state_e;

    typedef enum logic [1:0] {
        PH_NONE   = 2'd0,
        PH_FILL   = 2'd1,
        PH_CHECK  = 2'd2,
        PH_VERIFY = 2'd3
    } mst_phase_e;

endpackage

// File: rtl/mst_patgen.sv
module mst_patgen
    import mst_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mst_mode_e     mode,
    input  logic          restart,
    input  logic          step,
    output logic [DW-1:0] pat
);

    localparam logic [DW-1:0] SEED = DW'(1);

    logic [DW-1:0] pat_q;
    logic [DW-1:0] pat_nxt;

    // Successor of the current pattern for the selected sequence.
    always_comb begin
        unique case (mode)
            MODE_INTEG: pat_nxt = pat_q + DW'(1);
            MODE_BUS:   pat_nxt = {pat_q[DW-2:0], pat_q[DW-1]};
            default:    pat_nxt = pat_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= SEED;
        end else if (restart) begin
            pat_q <= SEED;
        end else if (step) begin
            pat_q <= pat_nxt;
        end
    end

    assign pat = pat_q;

    // R7
    bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BUS) |-> ($countones(pat_q) == 1));

endmodule

// File: rtl/mst_addr_seq.sv
module mst_addr_seq #(
    parameter int AW = 32,
    parameter int WB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] nwords,
    input  logic          clear,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);

    logic [AW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + AW'(1);
        end
    end

    assign addr = base + (idx_q << WB);
    assign last = (idx_q == nwords - AW'(1));

    // R3
    addr_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (addr == $past(addr) + AW'(1 << WB)));

endmodule

// File: rtl/mst_engine.sv
module mst_engine
    import mst_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] size_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_rvalid_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o,
    output logic [DW-1:0] exp_o,
    output logic [DW-1:0] act_o
);

    localparam int            WB        = $clog2(DW / 8);
    localparam int            BUS_WORDS = DW;
    localparam logic [AW:0]   ROUND_UP  = (AW + 1)'((1 << WB) - 1);

    mst_state_e    state_q, state_nxt;
    mst_phase_e    phase_q, phase_nxt;
    mst_mode_e     cfg_mode_q;
    logic [AW-1:0] cfg_base_q;
    logic [AW-1:0] cfg_nwords_q;

    logic          seq_clear;
    logic          seq_step;
    logic          accept;
    logic [AW:0]   size_ext;
    logic [AW-1:0] words_in;
    logic [AW-1:0] cur_addr;
    logic          cur_last;
    logic [DW-1:0] pat;
    logic [DW-1:0] expected;
    logic          rd_match;
    logic          rd_miss;

    logic          fail_q;
    logic [AW-1:0] fail_addr_q;
    logic [DW-1:0] exp_q;
    logic [DW-1:0] act_q;

    // Word count for the requested run.
    assign size_ext = {1'b0, size_i} + ROUND_UP;
    assign words_in = (mode_i == MODE_BUS) ? AW'(BUS_WORDS) : AW'(size_ext >> WB);

    assign accept   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    assign expected = (phase_q == PH_VERIFY) ? ~pat : pat;
    assign rd_match = (mem_rdata_i == expected);
    assign rd_miss  = (state_q == ST_RD_WAIT) && mem_rvalid_i && !rd_match;

    mst_addr_seq #(
        .AW (AW),
        .WB (WB)
    ) u_addr_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .base   (cfg_base_q),
        .nwords (cfg_nwords_q),
        .clear  (seq_clear),
        .step   (seq_step),
        .addr   (cur_addr),
        .last   (cur_last)
    );

    mst_patgen #(
        .DW (DW)
    ) u_patgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cfg_mode_q),
        .restart (seq_clear),
        .step    (seq_step),
        .pat     (pat)
    );

    // Next state, pass and sequencer control.
    always_comb begin
        state_nxt = state_q;
        phase_nxt = phase_q;
        seq_clear = 1'b0;
        seq_step  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    seq_clear = 1'b1;
                    if (words_in == '0) begin
                        state_nxt = ST_DONE;
                        phase_nxt = PH_NONE;
                    end else begin
                        state_nxt = ST_FILL;
                        phase_nxt = PH_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (cur_last) begin
                    seq_clear = 1'b1;
                    phase_nxt = PH_CHECK;
                    state_nxt = ST_RD_REQ;
                end else begin
                    seq_step  = 1'b1;
                end
            end
            ST_RD_REQ: begin
                state_nxt = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rvalid_i) begin
                    if (!rd_match) begin
                        state_nxt = ST_DONE;
                        phase_nxt = PH_NONE;
                    end else if (phase_q == PH_CHECK) begin
                        state_nxt = ST_INV_WR;
                    end else if (cur_last) begin
                        state_nxt = ST_DONE;
                        phase_nxt = PH_NONE;
                    end else begin
                        seq_step  = 1'b1;
                        state_nxt = ST_RD_REQ;
                    end
                end
            end
            ST_INV_WR: begin
                state_nxt = ST_RD_REQ;
                if (cur_last) begin
                    seq_clear = 1'b1;
                    phase_nxt = PH_VERIFY;
                end else begin
                    seq_step  = 1'b1;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                phase_nxt = PH_NONE;
            end
        endcase
    end

    // State register and run configuration.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            phase_q      <= PH_NONE;
            cfg_mode_q   <= MODE_INTEG;
            cfg_base_q   <= '0;
            cfg_nwords_q <= '0;
        end else begin
            state_q <= state_nxt;
            phase_q <= phase_nxt;
            if (accept) begin
                cfg_mode_q   <= mst_mode_e'(mode_i);
                cfg_base_q   <= base_i;
                cfg_nwords_q <= words_in;
            end
        end
    end

    // Failure record.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
            exp_q       <= '0;
            act_q       <= '0;
        end else if (accept) begin
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
            exp_q       <= '0;
            act_q       <= '0;
        end else if (rd_miss) begin
            fail_q      <= 1'b1;
            fail_addr_q <= cur_addr;
            exp_q       <= expected;
            act_q       <= mem_rdata_i;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = pat;
        unique case (state_q)
            ST_FILL: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
            end
            ST_RD_REQ: begin
                mem_req_o = 1'b1;
            end
            ST_INV_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = ~pat;
            end
            default: begin
            end
        endcase
    end

    assign mem_addr_o  = cur_addr;
    assign busy_o      = !(state_q == ST_IDLE || state_q == ST_DONE);
    assign done_o      = (state_q == ST_DONE);
    assign fail_o      = fail_q;
    assign fail_addr_o = fail_addr_q;
    assign exp_o       = exp_q;
    assign act_o       = act_q;

    // R8
    read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |=> !mem_req_o);

    // R6
    verify_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && phase_q == PH_VERIFY) |-> !mem_we_o);

    // R7
    bus_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && cfg_mode_q == MODE_BUS)
            |-> ($countones(mem_wdata_o) == 1 || $countones(mem_wdata_o) == DW - 1));

    // R9
    fail_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(fail_o) && $stable(fail_addr_o)
                                  && $stable(exp_o) && $stable(act_o)));

endmodule

// File: tb/test_mst_engine.sv
module test_mst_engine;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [AW-1:0] size_i = '0;
    logic          mem_req, mem_we, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          busy_o, done_o, fail_o;
    logic [AW-1:0] fail_addr_o;
    logic [DW-1:0] exp_o, act_o;

    int n_chk = 0;
    int n_fail = 0;

    // Memory model state.
    logic [31:0] mem [0:255];
    logic        pre_fill = 1'b0;
    logic [31:0] pre_val = '0;
    int          lat = 1;
    int          fault_word = -1;
    logic [31:0] sa0 = '0;
    logic [31:0] sa1 = '0;
    logic        spur = 1'b0;
    logic [31:0] rbuf = '0;
    int          rcnt = 0;
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          ovl = 0;

    always #5 clk = ~clk;

    mst_engine #(.AW(AW), .DW(DW)) i_mst_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .base_i       (base_i),
        .size_i       (size_i),
        .mem_req_o    (mem_req),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .mem_rdata_i  (mem_rdata),
        .mem_rvalid_i (mem_rvalid),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .fail_o       (fail_o),
        .fail_addr_o  (fail_addr_o),
        .exp_o        (exp_o),
        .act_o        (act_o)
    );

    assign mem_rvalid = (rcnt == 1) || spur;
    assign mem_rdata  = rbuf;

    always @(posedge clk) begin
        if (pre_fill) begin
            for (int k = 0; k < 256; k++) mem[k] <= pre_val;
        end else if (mem_req && mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_req && !mem_we) begin
            if (rcnt != 0) ovl <= ovl + 1;
            if (int'(mem_addr[9:2]) == fault_word)
                rbuf <= (mem[mem_addr[9:2]] & ~sa0) | sa1;
            else
                rbuf <= mem[mem_addr[9:2]];
            rcnt   <= lat;
            rd_cnt <= rd_cnt + 1;
        end else if (rcnt != 0) begin
            rcnt <= rcnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [31:0] v);
        @(negedge clk);
        pre_val  = v;
        pre_fill = 1'b1;
        @(negedge clk);
        pre_fill = 1'b0;
    endtask

    task automatic kick(input logic m, input logic [31:0] b, input logic [31:0] s);
        @(negedge clk);
        mode_i  = m;
        base_i  = b;
        size_i  = s;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done_o, "R11 run completes", 32'(done_o), 32'd1);
    endtask

    task automatic t_reset();
        check(!done_o && !fail_o && !busy_o && !mem_req, "R1 reset outputs",
              {28'd0, done_o, fail_o, busy_o, mem_req}, 32'd0);
    endtask

    task automatic t_integ_pass();
        int w0, r0;
        fault_word = -1;
        lat = 1;
        preload(32'hDEADBEEF);
        w0 = wr_cnt; r0 = rd_cnt;
        kick(1'b0, 32'h100, 32'd40);
        check(busy_o, "R2 busy after start", 32'(busy_o), 32'd1);
        wait_done();
        check(!fail_o, "R11 clean integrity run passes", 32'(fail_o), 32'd0);
        check(wr_cnt - w0 == 20, "R5 write count", 32'(wr_cnt - w0), 32'd20);
        check(rd_cnt - r0 == 20, "R6 read count", 32'(rd_cnt - r0), 32'd20);
        for (int i = 0; i < 10; i++)
            check(mem[64 + i] == ~32'(i + 1), "R5 inverted contents", mem[64 + i], ~32'(i + 1));
        check(mem[74] == 32'hDEADBEEF, "R3 word past range untouched", mem[74], 32'hDEADBEEF);
        check(mem[63] == 32'hDEADBEEF, "R3 word below base untouched", mem[63], 32'hDEADBEEF);
    endtask

    task automatic t_integ_fail_check();
        int w0, r0;
        preload(32'h0);
        fault_word = 67; sa1 = 32'h20; sa0 = '0;
        w0 = wr_cnt; r0 = rd_cnt;
        kick(1'b0, 32'h100, 32'd40);
        wait_done();
        check(fail_o, "R9 fail raised", 32'(fail_o), 32'd1);
        check(fail_addr_o == 32'h10C, "R9 fail address", fail_addr_o, 32'h10C);
        check(exp_o == 32'd4, "R9 expected value", exp_o, 32'd4);
        check(act_o == 32'h24, "R9 actual value", act_o, 32'h24);
        check(rd_cnt - r0 == 4, "R9 stops at first mismatch", 32'(rd_cnt - r0), 32'd4);
        check(wr_cnt - w0 == 13, "R5 writes before stop", 32'(wr_cnt - w0), 32'd13);
        check(mem[69] == 32'd6, "R4 first-pass value", mem[69], 32'd6);
        check(mem[66] == ~32'd3, "R5 complement written", mem[66], ~32'd3);
        fault_word = -1; sa1 = '0;
    endtask

    task automatic t_integ_fail_verify();
        fault_word = 2; sa0 = 32'h8000_0000; sa1 = '0;
        kick(1'b0, 32'h0, 32'd16);
        wait_done();
        check(fail_o, "R6 verify-pass fault caught", 32'(fail_o), 32'd1);
        check(fail_addr_o == 32'h8, "R6 fail address", fail_addr_o, 32'h8);
        check(exp_o == 32'hFFFF_FFFC, "R6 expected complement", exp_o, 32'hFFFF_FFFC);
        check(act_o == 32'h7FFF_FFFC, "R6 actual value", act_o, 32'h7FFF_FFFC);
        fault_word = -1; sa0 = '0;
    endtask

    task automatic t_bus_pass();
        int w0, r0;
        preload(32'h5A5A5A5A);
        w0 = wr_cnt; r0 = rd_cnt;
        kick(1'b1, 32'h200, 32'd0);
        wait_done();
        check(!fail_o, "R7 bus run passes", 32'(fail_o), 32'd0);
        check(wr_cnt - w0 == 64, "R7 bus write count", 32'(wr_cnt - w0), 32'd64);
        check(rd_cnt - r0 == 64, "R7 bus read count", 32'(rd_cnt - r0), 32'd64);
        check(mem[128] == ~32'h1, "R7 walking zero word 0", mem[128], ~32'h1);
        check(mem[135] == ~32'h80, "R7 walking zero word 7", mem[135], ~32'h80);
        check(mem[159] == ~32'h8000_0000, "R7 walking zero word 31", mem[159], ~32'h8000_0000);
        check(mem[160] == 32'h5A5A5A5A, "R3 bus range is 32 words", mem[160], 32'h5A5A5A5A);
    endtask

    task automatic t_bus_fail_hold();
        logic [31:0] fa;
        fault_word = 135; sa0 = 32'h80; sa1 = '0;
        kick(1'b1, 32'h200, 32'd0);
        wait_done();
        check(fail_o, "R7 bus stuck bit caught", 32'(fail_o), 32'd1);
        check(fail_addr_o == 32'h21C, "R9 bus fail address", fail_addr_o, 32'h21C);
        check(exp_o == 32'h80 && act_o == 32'h0, "R9 bus expected/actual", act_o, 32'h0);
        fa = fail_addr_o;
        repeat (20) @(negedge clk);
        check(done_o && fail_o && fail_addr_o == fa && exp_o == 32'h80, "R10 results held",
              fail_addr_o, fa);
        fault_word = -1; sa0 = '0;
        kick(1'b0, 32'h0, 32'd8);
        wait_done();
        check(!fail_o && fail_addr_o == 0 && act_o == 0, "R10 next start clears failure",
              fail_addr_o, 32'h0);
    endtask

    task automatic t_zero();
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        kick(1'b0, 32'h40, 32'd0);
        check(done_o && !fail_o && !busy_o, "R12 zero size finishes at once",
              {30'd0, done_o, fail_o}, 32'd2);
        repeat (3) @(negedge clk);
        check((wr_cnt - w0) + (rd_cnt - r0) == 0, "R12 no requests", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'd0);
    endtask

    task automatic t_busy_start();
        int w0;
        preload(32'h0);
        lat = 4;
        w0 = wr_cnt;
        kick(1'b0, 32'h0, 32'd32);
        repeat (10) @(negedge clk);
        check(busy_o, "R2 busy mid-run", 32'(busy_o), 32'd1);
        mode_i = 1'b1; base_i = 32'h300; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check(!fail_o && wr_cnt - w0 == 16, "R2 start while busy ignored", 32'(wr_cnt - w0), 32'd16);
        check(mem[7] == ~32'd8, "R2 original run contents", mem[7], ~32'd8);
        check(mem[192] == 32'h0, "R2 second base untouched", mem[192], 32'h0);
        lat = 1;
    endtask

    task automatic t_latency();
        int w0, r0, o0;
        preload(32'hFFFF_0000);
        lat = 3;
        w0 = wr_cnt; r0 = rd_cnt; o0 = ovl;
        kick(1'b0, 32'h80, 32'd10);
        spur = 1'b1;
        @(negedge clk);
        spur = 1'b0;
        wait_done();
        check(!fail_o, "R8 stray read-valid ignored", 32'(fail_o), 32'd0);
        check(ovl == o0, "R8 no read while one outstanding", 32'(ovl - o0), 32'd0);
        check(wr_cnt - w0 == 6 && rd_cnt - r0 == 6, "R3 ceil word count", 32'(wr_cnt - w0), 32'd6);
        check(mem[34] == ~32'd3, "R3 last partial word", mem[34], ~32'd3);
        check(mem[35] == 32'hFFFF_0000, "R3 no word beyond ceil", mem[35], 32'hFFFF_0000);
        lat = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_integ_pass();
        t_integ_fail_check();
        t_integ_fail_verify();
        t_bus_pass();
        t_bus_fail_hold();
        t_zero();
        t_busy_start();
        t_latency();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule